// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two thresholds that a synchronous FIFO's programmable flags compare against. The almost-empty offset counts words from the empty boundary and the almost-full offset counts words from the full boundary. Both offsets are driven out continuously to the flag generator. The FIFO storage, the pointers and the flag logic are outside this block.

One input, `prog_ld`, is sampled while master reset is held. A high level selects serial programming and loads both offsets with 0x3FF. A low level selects parallel programming and loads both offsets with 0x07F. Each default is clipped to all ones when the offset is narrower than the default. The chosen method stays in force until the next master reset.

After reset, `prog_ld` acts as the load qualifier. A write strobe writes the offsets through whichever port the mode selected. A read strobe returns the current offsets on the parallel output bus in either mode, because values cannot be read out serially.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrst` is high, `serial_mode` takes the value of `prog_ld` on every clock. After `mrst` falls, `serial_mode` holds that value until the next master reset, whatever `prog_ld` does.
- R2: After a master reset with `prog_ld` high, `ae_ofs` and `af_ofs` both equal 0x3FF, clipped to all ones if OFS_W is below 10.
- R3: After a master reset with `prog_ld` low, `ae_ofs` and `af_ofs` both equal 0x07F, clipped to all ones if OFS_W is below 7.
- R4: In parallel mode, each clock with `prog_ld` and `wr_stb` high writes `par_din` into one offset, starting with `ae_ofs` and then alternating with `af_ofs`. The written value shows on the output one clock later.
- R5: Each clock with `prog_ld` and `rd_stb` high presents one offset on `par_dout` one clock later, with `par_dout_vld` high for that one cycle. The first read after reset returns `ae_ofs`, and later reads alternate with `af_ofs`, using a pointer separate from the write pointer. A read returns the value held before any write made in the same clock. In all other cycles `par_dout_vld` is low.
- R6: In serial mode, each clock with `prog_ld` and `wr_stb` high stores `ser_in` into the next bit. The bits fill `ae_ofs` LSB first, then `af_ofs` LSB first. After bit OFS_W-1 of `af_ofs`, the next bit goes to bit 0 of `ae_ofs`.
- R7: A write strobe while `prog_ld` is low leaves both offsets unchanged. A read strobe while `prog_ld` is low returns nothing.
- R8: A master reset in the middle of a serial shift discards the partial sequence. The next shifted bit lands in bit 0 of `ae_ofs`.
- R9: Readback works in serial mode through `par_dout`. In parallel mode `ser_in` has no effect, and in serial mode `par_din` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prog_ld | input | 1 | Mode select while in reset; load qualifier after reset |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| ser_in | input | 1 | Serial data bit |
| par_din | input | OFS_W | Parallel write data |
| par_dout | output | OFS_W | Parallel readback data |
| par_dout_vld | output | 1 | Readback data valid |
| serial_mode | output | 1 | Latched programming method (1 = serial) |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |

## Verification
The bench runs a serial shift across the boundary between the two registers and on into the wrap. A counter that is off by one would put a bit in the wrong register or skip bit 0 when it wraps. It cuts a serial shift short with a master reset and then shifts again, which exposes a design that resumes from the old bit position. In parallel mode it issues a read and a write in the same clock and three writes in a row. A design whose read and write selects are swapped or shared, or whose read returns the newly written value, would then mismatch. Strobes with `prog_ld` low, wiggles on the unused data input, and changes of `prog_ld` after reset all check that nothing moves when it should not.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             prog_ld,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             ser_in,
  input  logic [OFS_W-1:0] par_din,
  output logic [OFS_W-1:0] par_dout,
  output logic             par_dout_vld,
  output logic             serial_mode,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam int unsigned SER_I = (OFS_W >= 10) ? 1023 : (1 << OFS_W) - 1;
  localparam int unsigned PAR_I = (OFS_W >= 7)  ? 127  : (1 << OFS_W) - 1;
  localparam logic [OFS_W-1:0] DEF_SER = SER_I[OFS_W-1:0];
  localparam logic [OFS_W-1:0] DEF_PAR = PAR_I[OFS_W-1:0];
  localparam int CW = $clog2(2 * OFS_W);
  localparam int IW = $clog2(OFS_W);
  localparam logic [CW-1:0] LAST = CW'(2 * OFS_W - 1);

  logic          wsel, rsel;
  logic [CW-1:0] cnt;

  wire           do_wr = prog_ld & wr_stb;
  wire           do_rd = prog_ld & rd_stb;
  wire           in_af = (cnt >= CW'(OFS_W));
  wire [CW-1:0]  pos   = in_af ? cnt - CW'(OFS_W) : cnt;
  wire [IW-1:0]  bidx  = pos[IW-1:0];

  always_ff @(posedge clk) begin
    if (mrst) begin
      serial_mode  <= prog_ld;
      ae_ofs       <= prog_ld ? DEF_SER : DEF_PAR;
      af_ofs       <= prog_ld ? DEF_SER : DEF_PAR;
      wsel         <= 1'b0;
      rsel         <= 1'b0;
      cnt          <= '0;
      par_dout     <= '0;
      par_dout_vld <= 1'b0;
    end else begin
      par_dout_vld <= do_rd;
      if (do_rd) begin
        par_dout <= rsel ? af_ofs : ae_ofs;
        rsel     <= ~rsel;
      end
      if (do_wr) begin
        if (serial_mode) begin
          if (in_af) af_ofs[bidx] <= ser_in;
          else       ae_ofs[bidx] <= ser_in;
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end else begin
          if (wsel) af_ofs <= par_din;
          else      ae_ofs <= par_din;
          wsel <= ~wsel;
        end
      end
    end
  end

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    $stable(serial_mode));

  // R2 R3
  default_val_chk: assert property (@(posedge clk) disable iff (mrst)
    $fell(mrst) |-> (ae_ofs == (serial_mode ? DEF_SER : DEF_PAR)) &&
                    (af_ofs == (serial_mode ? DEF_SER : DEF_PAR)));

  // R7
  no_load_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    !prog_ld |=> $stable(ae_ofs) && $stable(af_ofs));

  // R5
  rd_vld_chk: assert property (@(posedge clk) disable iff (mrst)
    (prog_ld && rd_stb) |=> par_dout_vld);

  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (mrst)
    !(prog_ld && rd_stb) |=> !par_dout_vld);

  // R4
  par_wr_chk: assert property (@(posedge clk) disable iff (mrst)
    (!serial_mode && prog_ld && wr_stb) |=>
      (ae_ofs == $past(par_din)) || (af_ofs == $past(par_din)));

  // R6
  ser_onebit_chk: assert property (@(posedge clk) disable iff (mrst)
    (serial_mode && prog_ld && wr_stb) |=>
      ($countones(ae_ofs ^ $past(ae_ofs)) + $countones(af_ofs ^ $past(af_ofs))) <= 1);
endmodule

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;
  localparam int W = 10;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic mrst = 1'b1, prog_ld = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0, ser_in = 1'b0;
  logic [W-1:0] par_din = '0;
  logic [W-1:0] par_dout, ae_ofs, af_ofs;
  logic par_dout_vld, serial_mode;

  int vec = 0, errs = 0;
  int m_mode, m_ae, m_af, m_wsel, m_rsel, m_cnt, m_dout, m_vld;

  flag_offset_loader #(.OFS_W(W)) dut (
    .clk(clk), .mrst(mrst), .prog_ld(prog_ld), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .ser_in(ser_in), .par_din(par_din), .par_dout(par_dout), .par_dout_vld(par_dout_vld),
    .serial_mode(serial_mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(string req, string what, int act, int exp);
    vec++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    if (mrst) begin
      m_mode = prog_ld;
      m_ae = prog_ld ? 'h3FF : 'h07F;
      m_af = m_ae;
      m_wsel = 0; m_rsel = 0; m_cnt = 0; m_dout = 0; m_vld = 0;
    end else begin
      m_vld = prog_ld && rd_stb;
      if (prog_ld && rd_stb) begin
        m_dout = m_rsel ? m_af : m_ae;
        m_rsel = 1 - m_rsel;
      end
      if (prog_ld && wr_stb) begin
        if (m_mode == 1) begin
          if (m_cnt < W) m_ae = (m_ae & ~(1 << m_cnt)) | (int'(ser_in) << m_cnt);
          else           m_af = (m_af & ~(1 << (m_cnt - W))) | (int'(ser_in) << (m_cnt - W));
          m_cnt = (m_cnt == 2*W-1) ? 0 : m_cnt + 1;
        end else begin
          if (m_wsel == 1) m_af = par_din; else m_ae = par_din;
          m_wsel = 1 - m_wsel;
        end
      end
    end
    #1;
    cmp(req, "serial_mode", serial_mode, m_mode);
    cmp(req, "ae_ofs", ae_ofs, m_ae);
    cmp(req, "af_ofs", af_ofs, m_af);
    cmp(req, "par_dout_vld", par_dout_vld, m_vld);
    cmp(req, "par_dout", par_dout, m_dout);
  endtask

  task automatic do_reset(logic ld, string req);
    mrst = 1'b1; prog_ld = ld; wr_stb = 0; rd_stb = 0;
    step(req); step(req);
    mrst = 1'b0; prog_ld = 0;
    step(req);
  endtask

  task automatic shift_word(int val, string req);
    for (int i = 0; i < W; i++) begin
      prog_ld = 1; wr_stb = 1; ser_in = val[i];
      step(req);
    end
    prog_ld = 0; wr_stb = 0;
  endtask

  task automatic rd(string req);
    prog_ld = 1; rd_stb = 1; step(req);
    prog_ld = 0; rd_stb = 0; step(req);
  endtask

  task automatic pwr(int val, string req);
    prog_ld = 1; wr_stb = 1; par_din = val[W-1:0]; step(req);
    prog_ld = 0; wr_stb = 0; step(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    // R1 R2: serial mode and its defaults
    do_reset(1'b1, "R2");
    cmp("R1", "mode serial", serial_mode, 1);
    cmp("R2", "ae default", ae_ofs, 'h3FF);
    cmp("R2", "af default", af_ofs, 'h3FF);
    // R9: readback in serial mode
    rd("R9"); rd("R9");
    // R6: ae then af, LSB first; par_din ignored (R9)
    par_din = 'h3C3;
    shift_word('h155, "R6");
    cmp("R6", "ae shifted", ae_ofs, 'h155);
    shift_word('h2AA, "R6");
    cmp("R6", "af shifted", af_ofs, 'h2AA);
    // R6: wrap returns to ae bit 0
    prog_ld = 1; wr_stb = 1; ser_in = 0; step("R6");
    prog_ld = 0; wr_stb = 0;
    cmp("R6", "wrap ae bit0", ae_ofs, 'h154);
    // R7: strobes without prog_ld
    wr_stb = 1; rd_stb = 1; ser_in = 1;
    for (int i = 0; i < 4; i++) step("R7");
    wr_stb = 0; rd_stb = 0;
    rd("R5"); rd("R5");
    // R8: partial shift then reset, restart at ae bit 0
    for (int i = 0; i < 5; i++) begin
      prog_ld = 1; wr_stb = 1; ser_in = 0; step("R8");
    end
    do_reset(1'b1, "R8");
    shift_word('h0A5, "R8");
    cmp("R8", "ae after restart", ae_ofs, 'h0A5);
    cmp("R8", "af untouched", af_ofs, 'h3FF);
    // R1 R3: parallel mode and its defaults
    do_reset(1'b0, "R3");
    cmp("R1", "mode parallel", serial_mode, 0);
    cmp("R3", "ae default", ae_ofs, 'h07F);
    cmp("R3", "af default", af_ofs, 'h07F);
    // R4: alternating writes; ser_in ignored (R9)
    ser_in = 1;
    pwr('h010, "R4");
    cmp("R4", "ae written", ae_ofs, 'h010);
    pwr('h3F0, "R4");
    cmp("R4", "af written", af_ofs, 'h3F0);
    pwr('h222, "R4");
    cmp("R4", "third write to ae", ae_ofs, 'h222);
    // R5: read and write in the same clock, separate pointers
    prog_ld = 1; rd_stb = 1; wr_stb = 1; par_din = 'h111; step("R5");
    cmp("R5", "read old ae", par_dout, 'h222);
    cmp("R5", "write af", af_ofs, 'h111);
    prog_ld = 1; rd_stb = 1; wr_stb = 0; step("R5");
    cmp("R5", "read af", par_dout, 'h111);
    prog_ld = 0; rd_stb = 0; step("R5");
    cmp("R5", "vld drops", par_dout_vld, 0);
    // R7: parallel write without prog_ld
    wr_stb = 1; par_din = 'h3FF; step("R7"); step("R7");
    wr_stb = 0;
    cmp("R7", "ae held", ae_ofs, 'h222);
    // R1: prog_ld toggling after reset keeps mode
    for (int i = 0; i < 6; i++) begin
      prog_ld = i[0]; step("R1");
    end
    prog_ld = 0;
    cmp("R1", "mode held", serial_mode, 0);
    step("R1");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule